// File: doc/BRIEF.md
# Multi-Queue Interrupt Mask Controller

This block collects interrupt events for a network controller with several priority queues. Each queue has its own 32-bit event input, status word, mask word and interrupt line. A main status word with its own mask sits beside the queue banks. All of these words are reached over a plain 32-bit register bus. Software never writes a mask directly. It sets bits through a write-one-to-disable register and clears them through a write-one-to-enable register, so it can change one source without a read-modify-write.

An event bit is latched into status only if the matching mask bit is clear. Status words clear when they are read. A queue's line is high while its status is nonzero. A read of the main status word pulls every queue line low. A line that was pulled low stays low until the next point where interrupts are re-evaluated: another register read, a write to any enable or disable register, or a new unmasked event on that queue. If the design is built with no priority queues, one legacy line follows the main status word instead.

The register bus has no back-pressure. A request is accepted in every cycle in which `bus_valid` is high. Read data is returned, with `rd_valid` high, in the cycle after the request.

Top module: `intq_irq_ctrl`

## Requirements
- R1: After reset every status word reads 0, every mask word reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: A write to a enable register clears, in that queue's mask, exactly the bits that are 1 in the written data. The other mask bits keep their value.
- R3: A write to a disable register sets, in that queue's mask, exactly the bits that are 1 in the written data. The other mask bits keep their value.
- R4: An event bit sets the matching status bit only where the mask bit is 0. A masked event leaves status unchanged.
- R5: A queue's interrupt output is high only while its status word is nonzero and the line is not held low.
- R6: A read of a queue status word returns its value and clears it. An event that arrives in the same cycle as the read survives in status.
- R7: In the cycle after a read of the main status word, every per-queue interrupt output is low, even if queue status is nonzero. The lines stay low while the bus is idle.
- R8: A held-low line is re-evaluated, and rises again if its status is nonzero, after any of these: a register read other than the main status read, a write to any enable or disable register, or an unmasked event on that queue.
- R9: The address map uses queue number n, counted from 1, and byte addresses.
  - Queue status is at 0x400+4(n-1).
  - Queue enable is at 0x600+4(n-1) for n≤7 and at 0x660+4(n-8) for n≥8.
  - Queue disable is at 0x620 and 0x680 on the same pattern.
  - Queue mask is at 0x640 and 0x6A0 on the same pattern.
  - The main words are status at 0x024, enable at 0x028, disable at 0x02C and mask at 0x030.
  - Enable and disable registers, and unmapped addresses, read as 0.
- R10: Every read request produces exactly one `rd_valid` pulse with its data, one cycle later. Writes produce no pulse.
- R11: With NUM_Q=0, `irq_main` is high exactly while the main status word is nonzero. With NUM_Q>0, `irq_main` stays low.
- R12: `ev_main` sets main status bits where the main mask is 0. Main status clears on read, and an event in the same cycle as the read wins over the clear.
- R13: Writes to status or mask addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| ev_main | input | 32 | Event bits for the main status word |
| ev_q | input | 32*max(NUM_Q,1) | Event bits, queue i in bits [32i+31:32i] |
| irq_q | output | max(NUM_Q,1) | Per-queue interrupt lines |
| irq_main | output | 1 | Legacy line (NUM_Q=0 only) |

## Verification
The bench drives a read and an event into the same cycle, for both a queue word and the main word. A design whose clear wins over the set would lose an interrupt there. It touches queues 7 and 8 to prove that the split enable and mask banks decode correctly; a flat stride would land writes on the wrong queue. It then pulls the lines low with a main status read and releases them, one at a time, by each of the three re-evaluation triggers. A design that treats the lowering as a one-cycle pulse, or that never lets the lines rise again, fails there. A second instance with no queues confirms that the legacy line follows main status.

// File: rtl/intq_pkg.sv
package intq_pkg;
  localparam int AW = 12;

  localparam logic [AW-1:0] MAIN_STAT = 12'h024;
  localparam logic [AW-1:0] MAIN_EN   = 12'h028;
  localparam logic [AW-1:0] MAIN_DIS  = 12'h02C;
  localparam logic [AW-1:0] MAIN_MASK = 12'h030;

  localparam logic [AW-1:0] QSTAT_BASE = 12'h400;
  localparam logic [AW-1:0] QEN_LO     = 12'h600;
  localparam logic [AW-1:0] QEN_HI     = 12'h660;
  localparam logic [AW-1:0] QDIS_LO    = 12'h620;
  localparam logic [AW-1:0] QDIS_HI    = 12'h680;
  localparam logic [AW-1:0] QMASK_LO   = 12'h640;
  localparam logic [AW-1:0] QMASK_HI   = 12'h6A0;

  // Queues below this index live in the low bank of the split ranges.
  localparam int LO_BANK_Q = 7;

  typedef enum logic [1:0] {RK_STAT, RK_EN, RK_DIS, RK_MASK} reg_kind_e;

  // Byte address of a register of queue q (zero-based).
  function automatic logic [AW-1:0] q_addr(reg_kind_e k, int q);
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    lo = QEN_LO;
    hi = QEN_HI;
    case (k)
      RK_STAT: return QSTAT_BASE + AW'(4 * q);
      RK_EN:   begin lo = QEN_LO;   hi = QEN_HI;   end
      RK_DIS:  begin lo = QDIS_LO;  hi = QDIS_HI;  end
      default: begin lo = QMASK_LO; hi = QMASK_HI; end
    endcase
    if (q < LO_BANK_Q) return lo + AW'(4 * q);
    return hi + AW'(4 * (q - LO_BANK_Q));
  endfunction
endpackage

// File: rtl/intq_addr_decode.sv
module intq_addr_decode
  import intq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int NU    = 9
) (
  input  logic [AW-1:0] addr,
  output logic [NU-1:0] sel_stat,
  output logic [NU-1:0] sel_en,
  output logic [NU-1:0] sel_dis,
  output logic [NU-1:0] sel_mask
);
  localparam int MI = NU - 1;

  always_comb begin
    sel_stat = '0;
    sel_en   = '0;
    sel_dis  = '0;
    sel_mask = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      sel_stat[i] = (addr == q_addr(RK_STAT, i));
      sel_en[i]   = (addr == q_addr(RK_EN, i));
      sel_dis[i]  = (addr == q_addr(RK_DIS, i));
      sel_mask[i] = (addr == q_addr(RK_MASK, i));
    end
    sel_stat[MI] = (addr == MAIN_STAT);
    sel_en[MI]   = (addr == MAIN_EN);
    sel_dis[MI]  = (addr == MAIN_DIS);
    sel_mask[MI] = (addr == MAIN_MASK);
  end
endmodule

// File: rtl/intq_reg_unit.sv
module intq_reg_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev,
  input  logic          en_wr,
  input  logic          dis_wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clr,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] status_d;
  logic [DW-1:0] mask_d;

  always_comb begin
    // Set wins over clear-on-read; the gate uses the mask held before this edge.
    status_d = (rd_clr ? '0 : status) | (ev & ~mask);
    mask_d   = mask;
    if (en_wr)  mask_d = mask_d & ~wdata;
    if (dis_wr) mask_d = mask_d | wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= status_d;
      mask   <= mask_d;
    end
  end
endmodule

// File: rtl/intq_irq_ctrl.sv
module intq_irq_ctrl
  import intq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int DW    = 32,
  localparam int NQ_W = (NUM_Q == 0) ? 1 : NUM_Q
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     ev_main,
  input  logic [NQ_W*DW-1:0] ev_q,
  output logic [NQ_W-1:0]   irq_q,
  output logic              irq_main
);
  localparam int NU = NQ_W + 1;
  localparam int MI = NQ_W;

  logic rd_en, wr_en, main_rd, other_rd, mask_touch;
  logic [NU-1:0] sel_stat, sel_en, sel_dis, sel_mask;
  logic [NU-1:0][DW-1:0] stat_v;
  logic [NU-1:0][DW-1:0] mask_v;
  logic [NQ_W*DW-1:0] stat_all;
  logic [NQ_W*DW-1:0] mask_all;
  logic [DW-1:0] rd_mux;

  assign rd_en      = bus_valid & ~bus_write;
  assign wr_en      = bus_valid & bus_write;
  assign main_rd    = rd_en & sel_stat[MI];
  assign other_rd   = rd_en & ~sel_stat[MI];
  assign mask_touch = wr_en & ((|sel_en) | (|sel_dis));

  intq_addr_decode #(.NUM_Q(NUM_Q), .NU(NU)) u_dec (
    .addr     (bus_addr),
    .sel_stat (sel_stat),
    .sel_en   (sel_en),
    .sel_dis  (sel_dis),
    .sel_mask (sel_mask)
  );

  intq_reg_unit #(.DW(DW)) u_main (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev_main),
    .en_wr  (wr_en & sel_en[MI]),
    .dis_wr (wr_en & sel_dis[MI]),
    .wdata  (bus_wdata),
    .rd_clr (main_rd),
    .status (stat_v[MI]),
    .mask   (mask_v[MI])
  );

  generate
    if (NUM_Q > 0) begin : g_q
      for (genvar i = 0; i < NUM_Q; i++) begin : g_u
        logic hold;
        logic ev_hit;

        intq_reg_unit #(.DW(DW)) u_reg (
          .clk    (clk),
          .rst    (rst),
          .ev     (ev_q[i*DW +: DW]),
          .en_wr  (wr_en & sel_en[i]),
          .dis_wr (wr_en & sel_dis[i]),
          .wdata  (bus_wdata),
          .rd_clr (rd_en & sel_stat[i]),
          .status (stat_v[i]),
          .mask   (mask_v[i])
        );

        assign ev_hit = |(ev_q[i*DW +: DW] & ~mask_v[i]);

        // Line held low after a main status read until the next re-evaluation point.
        always_ff @(posedge clk) begin
          if (rst)                                   hold <= 1'b0;
          else if (main_rd)                          hold <= 1'b1;
          else if (other_rd || mask_touch || ev_hit) hold <= 1'b0;
        end

        assign irq_q[i]             = (|stat_v[i]) & ~hold;
        assign stat_all[i*DW +: DW] = stat_v[i];
        assign mask_all[i*DW +: DW] = mask_v[i];
      end
      assign irq_main = 1'b0;
    end else begin : g_leg
      assign stat_v[0] = '0;
      assign mask_v[0] = '0;
      assign irq_q     = '0;
      assign stat_all  = '0;
      assign mask_all  = '0;
      assign irq_main  = |stat_v[MI];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int j = 0; j < NU; j++) begin
      if (sel_stat[j]) rd_mux = rd_mux | stat_v[j];
      if (sel_mask[j]) rd_mux = rd_mux | mask_v[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/intq_irq_chk.sv
module intq_irq_chk
  import intq_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int DW    = 32,
  localparam int NQ_W = (NUM_Q == 0) ? 1 : NUM_Q
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic               rd_valid,
  input logic [NQ_W-1:0]    irq_q,
  input logic [NQ_W*DW-1:0] stat_all,
  input logic [NQ_W*DW-1:0] mask_all
);
  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_c
      p_en_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == q_addr(RK_EN, q))
        |=> ((mask_all[q*DW +: DW] & $past(bus_wdata)) == '0));

      p_dis_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == q_addr(RK_DIS, q))
        |=> ((mask_all[q*DW +: DW] & $past(bus_wdata)) == $past(bus_wdata)));

      p_masked_ev_r4: assert property (@(posedge clk) disable iff (rst)
        ((stat_all[q*DW +: DW] & ~$past(stat_all[q*DW +: DW])
          & $past(mask_all[q*DW +: DW])) == '0));

      p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (rst)
        irq_q[q] |-> (stat_all[q*DW +: DW] != '0));
    end

    if (NUM_Q > 0) begin : g_main
      p_main_rd_lowers_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == MAIN_STAT) |=> (irq_q == '0));
    end
  endgenerate

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rd_valid);

  p_no_spurious_rd_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !rd_valid);
endmodule

bind intq_irq_ctrl intq_irq_chk #(.NUM_Q(NUM_Q), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .irq_q     (irq_q),
  .stat_all  (stat_all),
  .mask_all  (mask_all)
);

// File: tb/intq_irq_ctrl_tb.sv
module intq_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] ev_main = '0;
  logic [NQ*32-1:0] ev_q = '0;
  logic rd_valid, l_rd_valid;
  logic [31:0] rd_data, l_rd_data;
  logic [NQ-1:0] irq_q;
  logic irq_main, l_irq_main;
  logic [0:0] l_irq_q;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intq_irq_ctrl #(.NUM_Q(NQ)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ev_main(ev_main), .ev_q(ev_q), .irq_q(irq_q),
    .irq_main(irq_main));

  intq_irq_ctrl #(.NUM_Q(0)) u_leg (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(l_rd_valid),
    .rd_data(l_rd_data), .ev_main(ev_main), .ev_q(32'h0), .irq_q(l_irq_q),
    .irq_main(l_irq_main));

  function automatic logic [11:0] a_st(int n);
    return 12'h400 + 12'(4*(n-1));
  endfunction
  function automatic logic [11:0] a_en(int n);
    return (n <= 7) ? 12'h600 + 12'(4*(n-1)) : 12'h660 + 12'(4*(n-8));
  endfunction
  function automatic logic [11:0] a_dis(int n);
    return (n <= 7) ? 12'h620 + 12'(4*(n-1)) : 12'h680 + 12'(4*(n-8));
  endfunction
  function automatic logic [11:0] a_mask(int n);
    return (n <= 7) ? 12'h640 + 12'(4*(n-1)) : 12'h6A0 + 12'(4*(n-8));
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Called at a negedge; applies one cycle of stimulus and returns at the next negedge.
  task automatic drive(bit v, bit w, logic [11:0] a, logic [31:0] d,
                       int qi, logic [31:0] eb, logic [31:0] em);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    ev_q = '0;
    if (qi >= 0) ev_q[qi*32 +: 32] = eb;
    ev_main = em;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ev_q = '0; ev_main = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    drive(1, 1, a, d, -1, 0, 0);
  endtask
  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    drive(1, 0, a, 0, -1, 0, 0);
  endtask
  task automatic rd_ev(logic [11:0] a, logic [31:0] exp, string tag,
                       int qi, logic [31:0] eb, logic [31:0] em);
    exp_q.push_back(exp); tag_q.push_back(tag);
    drive(1, 0, a, 0, qi, eb, em);
  endtask
  task automatic ev(int qi, logic [31:0] eb);
    drive(0, 0, 0, 0, qi, eb, 0);
  endtask
  task automatic idle();
    drive(0, 0, 0, 0, -1, 0, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected rd_valid", rd_data, 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(irq_q == 0, "R1 irq_q", 32'(irq_q), 0);
    check(irq_main == 0 && l_irq_main == 0, "R1 irq_main", {31'b0, irq_main | l_irq_main}, 0);
    rd(a_mask(1), 32'hFFFF_FFFF, "R1 q1 mask");
    rd(a_st(1), 32'h0, "R1 q1 status");
    rd(12'h030, 32'hFFFF_FFFF, "R1 main mask");

    // R4 masked event ignored
    ev(0, 32'h0F);
    check(irq_q == 0, "R4 masked irq", 32'(irq_q), 0);
    rd(a_st(1), 32'h0, "R4 masked status");

    // R2 / R3 enable and disable
    wr(a_en(1), 32'hF0);
    check(rd_valid == 0, "R10 no rd_valid on write", {31'b0, rd_valid}, 0);
    rd(a_mask(1), 32'hFFFF_FF0F, "R2 enable clears");
    wr(a_dis(1), 32'h30);
    rd(a_mask(1), 32'hFFFF_FF3F, "R3 disable sets");

    // R4 / R5 / R6
    ev(0, 32'hFF);
    check(irq_q == 8'h01, "R5 irq on status", 32'(irq_q), 32'h01);
    rd(a_st(1), 32'hC0, "R4 only unmasked bits");
    check(irq_q == 8'h00, "R6 clear on read", 32'(irq_q), 0);

    ev(0, 32'h40);
    rd_ev(a_st(1), 32'h40, "R6 read value", 0, 32'h80, 0);
    rd(a_st(1), 32'h80, "R6 set wins over clear");

    // R9 split banks: queues 7 and 8
    wr(a_en(8), 32'h1);
    rd(a_mask(8), 32'hFFFF_FFFE, "R9 q8 mask high bank");
    rd(a_mask(7), 32'hFFFF_FFFF, "R9 q7 untouched");
    wr(a_en(7), 32'h2);
    rd(a_mask(7), 32'hFFFF_FFFD, "R9 q7 mask low bank");
    ev(7, 32'h3);
    ev(6, 32'h3);
    check(irq_q == 8'hC0, "R5 q7 q8 lines", 32'(irq_q), 32'hC0);

    // R7 main read lowers lines
    rd(12'h024, 32'h0, "R7 main status");
    check(irq_q == 8'h00, "R7 lowered", 32'(irq_q), 0);
    idle(); idle();
    check(irq_q == 8'h00, "R7 stays low idle", 32'(irq_q), 0);

    // R8 re-evaluation triggers
    wr(a_dis(2), 32'h0);
    check(irq_q == 8'hC0, "R8 mask write re-eval", 32'(irq_q), 32'hC0);
    rd(12'h024, 32'h0, "R7 main status again");
    check(irq_q == 8'h00, "R7 lowered again", 32'(irq_q), 0);
    ev(7, 32'h1);
    check(irq_q == 8'h80, "R8 event re-eval own queue", 32'(irq_q), 32'h80);
    rd(a_mask(1), 32'hFFFF_FF3F, "R8 read data");
    check(irq_q == 8'hC0, "R8 read re-eval", 32'(irq_q), 32'hC0);
    rd(a_st(8), 32'h1, "R9 q8 status");
    rd(a_st(7), 32'h2, "R9 q7 status");
    check(irq_q == 8'h00, "R6 all cleared", 32'(irq_q), 0);

    // R12 / R11 main word and legacy line
    wr(12'h028, 32'h5);
    ev(-1, 0);
    drive(0, 0, 0, 0, -1, 0, 32'hF);
    check(irq_main == 0, "R11 irq_main low with queues", {31'b0, irq_main}, 0);
    check(l_irq_main == 1, "R11 legacy line high", {31'b0, l_irq_main}, 1);
    rd_ev(12'h024, 32'h5, "R12 main status", -1, 0, 32'h1);
    check(l_rd_data == 32'h5, "R11 legacy read data", l_rd_data, 32'h5);
    check(l_irq_main == 1, "R12 legacy set wins", {31'b0, l_irq_main}, 1);
    rd(12'h024, 32'h1, "R12 main set wins over clear");
    check(l_irq_main == 0, "R11 legacy line drops", {31'b0, l_irq_main}, 0);
    rd(12'h030, 32'hFFFF_FFFA, "R12 main mask");

    // R13 / R9 ignored writes and reads of write-only or unmapped words
    wr(a_st(1), 32'hFFFF);
    wr(a_mask(1), 32'h0);
    rd(a_mask(1), 32'hFFFF_FF3F, "R13 mask write ignored");
    rd(a_st(1), 32'h0, "R13 status write ignored");
    rd(a_en(1), 32'h0, "R9 enable reads zero");
    rd(12'h7FC, 32'h0, "R9 unmapped reads zero");

    idle(); idle();
    check(exp_q.size() == 0, "R10 all reads answered", 32'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule